// File: doc/BRIEF.md
# Pausing Two-Level Static Schedule Controller

This block sequences a fixed-latency schedule of groups. A parent counter walks a list of parent steps. One of them, the handoff step, is a counted loop. A child counter runs that loop: it walks a body of several cycles a fixed number of times. While the child runs, the parent counter holds its value. The parent state register therefore needs only enough bits to number the parent steps. It does not need bits for every cycle of the whole schedule.

The block has one strobe for each group. Parent groups are driven from the parent counter. Body groups are driven from the child counter. A single `go` pulse, taken while the block is idle, starts one pass of the schedule. `done` marks the final active cycle, and both counters then go back to zero. Downstream datapath logic uses the enable strobes directly as group enables.

The parameters are:
- `PAR_STEPS`: the number of parent steps, at least 2.
- `HAND_IDX`: the index of the handoff step.
- `BODY_LEN`: the number of cycles in the loop body.
- `REPEATS`: the number of loop passes.

The parent register is `$clog2(PAR_STEPS)` bits wide.

The parent controller has three states:
- **IDLE**: waiting for `go`.
- **STEP**: a one-cycle parent group is running.
- **HOLD**: the parent is frozen at the handoff step while the child counter runs.

Its transitions are:
- **start**: IDLE to STEP, or IDLE to HOLD when `HAND_IDX` is 0.
- **advance**: STEP to STEP.
- **handoff**: STEP to HOLD, taken when the next step is the handoff step.
- **resume**: HOLD to STEP, taken on the child's final cycle.
- **finish**: STEP or HOLD to IDLE, taken on the last parent step.

Top module: `pausing_sched`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it rises, the block returns to idle. In idle, every bit of `par_en` and `kid_en` is low and `done` is low.
- R2: When `go` is high at a clock edge while the block is idle, the next cycle is the first active cycle. In that cycle only the enable of parent step 0 is high, which is `par_en[0]` when `HAND_IDX` is not 0.
- R3: Every parent step other than the handoff step lasts exactly one cycle, and the steps run in ascending order. Step s drives `par_en[s]` when s is below `HAND_IDX`, and `par_en[s-1]` when s is above it.
- R4: At the handoff step, `kid_en[0]` up to `kid_en[BODY_LEN-1]` are raised one per cycle in ascending order. This body walk is repeated `REPEATS` times back to back.
- R5: While the child counter runs, every bit of `par_en` stays low and the parent counter keeps its value.
- R6: In the cycle after the child's final cycle, the enable of parent step `HAND_IDX+1` is high, which is `par_en[HAND_IDX]`.
- R7: In every active cycle exactly one bit of `{par_en, kid_en}` is high. In every idle cycle none is high.
- R8: `done` is high for exactly one cycle, which is active cycle number `PAR_STEPS - 1 + REPEATS*BODY_LEN`. That cycle is the last step's enable cycle, and active cycle 1 is the cycle after the edge that took `go`.
- R9: `go` has no effect while the block is active, including the `done` cycle. After `done`, the block is idle with both counters at zero, and a new `go` repeats the identical enable sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Start request, taken only while idle |
| par_en | output | PAR_STEPS-1 | One strobe per non-handoff parent step |
| kid_en | output | BODY_LEN | One strobe per loop-body cycle |
| done | output | 1 | High in the final active cycle of a pass |

## Verification
The hardest situations to reach from the ports are the boundaries around the frozen parent. One is the resume edge from the last body cycle of the last repeat back into a parent step. The other is a `go` that arrives exactly in the `done` cycle. The bench holds `go` high across several whole passes, so a request is present in every active cycle and in the `done` cycle. It also pulses `go` mid-pass and applies a reset in the middle of the loop. A behavioural model expands the schedule into a queue of expected strobes and is compared with the outputs on every cycle.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_STEP = 2'd1,
        PS_HOLD = 2'd2
    } par_state_e;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sched_parent.sv
module sched_parent
    import sched_pkg::*;
#(
    parameter int PAR_STEPS = 5,
    parameter int HAND_IDX  = 2,
    parameter int PW        = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          kid_last,
    output par_state_e    st,
    output logic [PW-1:0] pcnt,
    output logic          kid_run,
    output logic          done
);

    localparam logic [PW-1:0] LAST_C = PW'(PAR_STEPS - 1);
    localparam logic [PW-1:0] HAND_C = PW'(HAND_IDX);

    par_state_e    st_d;
    logic [PW-1:0] pcnt_d;
    logic [PW-1:0] pcnt_inc;

    assign pcnt_inc = pcnt + 1'b1;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= PS_IDLE;
            pcnt <= '0;
        end else begin
            st   <= st_d;
            pcnt <= pcnt_d;
        end
    end

    // transitions
    always_comb begin
        st_d   = st;
        pcnt_d = pcnt;
        unique case (st)
            PS_IDLE: begin
                if (go) begin
                    pcnt_d = '0;
                    st_d   = (HAND_C == '0) ? PS_HOLD : PS_STEP;
                end
            end
            PS_STEP: begin
                if (pcnt == LAST_C) begin
                    st_d   = PS_IDLE;
                    pcnt_d = '0;
                end else begin
                    pcnt_d = pcnt_inc;
                    st_d   = (pcnt_inc == HAND_C) ? PS_HOLD : PS_STEP;
                end
            end
            PS_HOLD: begin
                if (kid_last) begin
                    if (pcnt == LAST_C) begin
                        st_d   = PS_IDLE;
                        pcnt_d = '0;
                    end else begin
                        st_d   = PS_STEP;
                        pcnt_d = pcnt_inc;
                    end
                end
            end
            default: begin
                st_d   = PS_IDLE;
                pcnt_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        kid_run = 1'b0;
        done    = 1'b0;
        unique case (st)
            PS_IDLE: ;
            PS_STEP: done = (pcnt == LAST_C);
            PS_HOLD: begin
                kid_run = 1'b1;
                done    = kid_last && (pcnt == LAST_C);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sched_child.sv
module sched_child #(
    parameter int BODY_LEN = 3,
    parameter int REPEATS  = 4,
    parameter int BW       = 2,
    parameter int RW       = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    output logic [BW-1:0] bcnt,
    output logic          kid_last
);

    localparam logic [BW-1:0] B_LAST = BW'(BODY_LEN - 1);
    localparam logic [RW-1:0] R_LAST = RW'(REPEATS - 1);

    logic [RW-1:0] icnt;
    logic          body_end;

    assign body_end = (bcnt == B_LAST);
    assign kid_last = run && body_end && (icnt == R_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            bcnt <= '0;
            icnt <= '0;
        end else if (body_end) begin
            bcnt <= '0;
            icnt <= (icnt == R_LAST) ? '0 : icnt + 1'b1;
        end else begin
            bcnt <= bcnt + 1'b1;
        end
    end

endmodule

// File: rtl/sched_decode.sv
module sched_decode
    import sched_pkg::*;
#(
    parameter int PAR_STEPS = 5,
    parameter int HAND_IDX  = 2,
    parameter int BODY_LEN  = 3,
    parameter int PW        = 3,
    parameter int BW        = 2
) (
    input  par_state_e            st,
    input  logic [PW-1:0]         pcnt,
    input  logic [BW-1:0]         bcnt,
    output logic [PAR_STEPS-2:0]  par_en,
    output logic [BODY_LEN-1:0]   kid_en
);

    localparam int NPG = PAR_STEPS - 1;

    logic in_step;
    logic in_hold;

    assign in_step = (st == PS_STEP);
    assign in_hold = (st == PS_HOLD);

    for (genvar g = 0; g < NPG; g++) begin : g_par
        localparam int STEP_NO = (g < HAND_IDX) ? g : g + 1;
        assign par_en[g] = in_step && (pcnt == PW'(STEP_NO));
    end

    for (genvar k = 0; k < BODY_LEN; k++) begin : g_kid
        assign kid_en[k] = in_hold && (bcnt == BW'(k));
    end

endmodule

// File: rtl/pausing_sched.sv
module pausing_sched
    import sched_pkg::*;
#(
    parameter int PAR_STEPS = 5,
    parameter int HAND_IDX  = 2,
    parameter int BODY_LEN  = 3,
    parameter int REPEATS   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    output logic [PAR_STEPS-2:0] par_en,
    output logic [BODY_LEN-1:0]  kid_en,
    output logic                 done
);

    localparam int PW = cnt_width(PAR_STEPS);
    localparam int BW = cnt_width(BODY_LEN);
    localparam int RW = cnt_width(REPEATS);

    par_state_e    st;
    logic [PW-1:0] pcnt;
    logic [BW-1:0] bcnt;
    logic          kid_run;
    logic          kid_last;

    sched_parent #(
        .PAR_STEPS(PAR_STEPS), .HAND_IDX(HAND_IDX), .PW(PW)
    ) u_par (
        .clk(clk), .rst(rst), .go(go), .kid_last(kid_last),
        .st(st), .pcnt(pcnt), .kid_run(kid_run), .done(done)
    );

    sched_child #(
        .BODY_LEN(BODY_LEN), .REPEATS(REPEATS), .BW(BW), .RW(RW)
    ) u_kid (
        .clk(clk), .rst(rst), .run(kid_run),
        .bcnt(bcnt), .kid_last(kid_last)
    );

    sched_decode #(
        .PAR_STEPS(PAR_STEPS), .HAND_IDX(HAND_IDX), .BODY_LEN(BODY_LEN),
        .PW(PW), .BW(BW)
    ) u_dec (
        .st(st), .pcnt(pcnt), .bcnt(bcnt),
        .par_en(par_en), .kid_en(kid_en)
    );

endmodule

// File: rtl/pausing_sched_chk.sv
module pausing_sched_chk
    import sched_pkg::*;
#(
    parameter int PAR_STEPS = 5,
    parameter int BODY_LEN  = 3,
    parameter int PW        = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic [PAR_STEPS-2:0] par_en,
    input logic [BODY_LEN-1:0]  kid_en,
    input logic                 done,
    input par_state_e           st,
    input logic [PW-1:0]        pcnt,
    input logic                 kid_last
);

    a_r7_one_active: assert property (@(posedge clk) disable iff (rst)
        (st != PS_IDLE) |-> ($countones({par_en, kid_en}) == 1));

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == PS_IDLE) |-> ({par_en, kid_en} == '0 && !done));

    a_r5_parent_frozen: assert property (@(posedge clk) disable iff (rst)
        (st == PS_HOLD && !kid_last) |=> (st == PS_HOLD && pcnt == $past(pcnt)));

    a_r5_no_parent_en: assert property (@(posedge clk) disable iff (rst)
        (st == PS_HOLD) |-> (par_en == '0));

    a_r6_resume_next: assert property (@(posedge clk) disable iff (rst)
        (st == PS_HOLD && kid_last && !done) |=> (st == PS_STEP && pcnt == $past(pcnt) + 1'b1));

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_zero_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> (st == PS_IDLE && pcnt == '0));

endmodule

bind pausing_sched pausing_sched_chk #(
    .PAR_STEPS(PAR_STEPS), .BODY_LEN(BODY_LEN), .PW(PW)
) u_chk (
    .clk(clk), .rst(rst), .par_en(par_en), .kid_en(kid_en), .done(done),
    .st(st), .pcnt(pcnt), .kid_last(kid_last)
);

// File: tb/sim_pausing_sched.sv
module sim_pausing_sched;

    localparam int CLK_PERIOD = 10;
    localparam int PAR_STEPS  = 5;
    localparam int HAND_IDX   = 2;
    localparam int BODY_LEN   = 3;
    localparam int REPEATS    = 4;
    localparam int LAT        = PAR_STEPS - 1 + REPEATS * BODY_LEN;
    localparam int KID_BASE   = 1000;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 go  = 1'b0;
    logic [PAR_STEPS-2:0] par_en;
    logic [BODY_LEN-1:0]  kid_en;
    logic                 done;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    int start_cyc = -1000;
    int exp_q[$];
    bit prev_kid = 1'b0;
    bit finished = 1'b0;

    pausing_sched #(
        .PAR_STEPS(PAR_STEPS), .HAND_IDX(HAND_IDX),
        .BODY_LEN(BODY_LEN), .REPEATS(REPEATS)
    ) u0 (
        .clk(clk), .rst(rst), .go(go),
        .par_en(par_en), .kid_en(kid_en), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic fill_schedule();
        for (int s = 0; s < PAR_STEPS; s++) begin
            if (s == HAND_IDX) begin
                for (int r = 0; r < REPEATS; r++)
                    for (int k = 0; k < BODY_LEN; k++)
                        exp_q.push_back(KID_BASE + k);
            end else begin
                exp_q.push_back((s < HAND_IDX) ? s : s - 1);
            end
        end
    endtask

    // reference model: one queue entry per active cycle
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            exp_q.delete();
        end else if (exp_q.size() != 0) begin
            void'(exp_q.pop_front());
        end else if (go) begin
            fill_schedule();
            start_cyc = cyc;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            logic [PAR_STEPS-2:0] e_par;
            logic [BODY_LEN-1:0]  e_kid;
            bit    e_done;
            bit    is_kid;
            string tag;
            e_par  = '0;
            e_kid  = '0;
            e_done = 1'b0;
            is_kid = 1'b0;
            tag    = "R7";
            if (exp_q.size() != 0) begin
                if (exp_q[0] >= KID_BASE) begin
                    e_kid[exp_q[0] - KID_BASE] = 1'b1;
                    is_kid = 1'b1;
                    tag = "R4";
                end else begin
                    e_par[exp_q[0]] = 1'b1;
                    tag = "R3";
                end
                e_done = (exp_q.size() == 1);
                if (cyc == start_cyc) tag = "R2";
                if (prev_kid && !is_kid) tag = "R6";
                chk($countones({par_en, kid_en}) == 1, "R7", $countones({par_en, kid_en}), 1);
            end
            chk(par_en == e_par, is_kid ? "R5" : tag, int'(par_en), int'(e_par));
            chk(kid_en == e_kid, tag, int'(kid_en), int'(e_kid));
            chk(done == e_done, "R8", int'(done), int'(e_done));
            if (done)
                chk(cyc - start_cyc + 1 == LAT, "R8", cyc - start_cyc + 1, LAT);
            prev_kid = is_kid;
        end
    end

    task automatic idle_check(input string req);
        chk(par_en == '0 && kid_en == '0 && !done, req, int'({par_en, kid_en, done}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        idle_check("R1");
        rst = 1'b0;
        @(negedge clk);
        // single pass from a one-cycle go
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        repeat (LAT + 4) @(negedge clk);
        idle_check("R9");
        // go held high through several passes: ignored while active, restarts after done (R9)
        go = 1'b1;
        repeat (3 * (LAT + 1) + 2) @(negedge clk);
        go = 1'b0;
        repeat (LAT + 4) @(negedge clk);
        // stray go pulses in the middle of a pass (R9)
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        repeat (4) @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        repeat (6) @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        repeat (LAT) @(negedge clk);
        // reset while the child counter runs (R1)
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        idle_check("R1");
        rst = 1'b0;
        @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        repeat (LAT + 4) @(negedge clk);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule